// File: doc/BRIEF.md
# Clock Generator Configuration Register Bank

This block keeps the configuration state of a system clock generator. Software reaches it through a small byte-wide port: an address, a write enable with write data, and a read data bus that follows the address in the same cycle. The block drives the per-output enable vectors used by the clock gating logic. It also drives the effective 5-bit frequency code, the spread-spectrum enable, and the decoded CPU, PCI and AGP target frequencies for the synthesizer.

While reset is held, the block samples three frequency-select strap pins. Those straps set the default frequency. A source-select bit in the mode register decides where the frequency code and the spread enable come from. With the bit clear, both come from the latched straps and the live active-low spread pin. With the bit set, both come from register fields. A one-cycle reload strobe tells the synthesizer that the effective code has changed.

Top module: `clkgen_cfg_bank`

## Requirements
- R1: While reset is held, every register takes its reset value. The output-enable register and the PCI-enable register reset to 8'hFF. The mode register resets to {spread=0, code=2'b00 followed by the strap pins, src=0, sdram=1}. freqReload is 0 once reset is released.
- R2: The strap pins fsPins are sampled on each clock edge while rstN is low and then held. A strap change after reset has no effect on freqCode or on the mode register readback.
- R3: With mode bit 1 = 0 (pin source), freqCode = {2'b00, latched straps} and spreadOn = !spreadPinN.
- R4: With mode bit 1 = 1 (register source), freqCode = mode bits 6:2 and spreadOn = mode bit 7. spreadPinN then has no effect.
- R5: Output-enable register at address 0: bit 7 drives refEn[0], bit 6 drives clk2448En, bit 5 drives clk48En, bits 4:3 drive agpEn[1:0], and bits 2:0 drive cpuEn[2:0].
- R6: PCI-enable register at address 1: bit 7 drives refEn[1], and bits 6:0 drive pciEn[6:0].
- R7: Mode register at address 2: bit 0 drives sdramFbEn.
- R8: cpuFreq is given in units of 10 kHz. Codes 0 to 31 give, in code order: 13333, 9500, 10099, 11500, 10070, 10300, 10500, 11000, 10200, 10400, 10600, 10700, 10800, 10900, 9000, 11100, 11200, 11300, 11400, 11600, 11700, 11800, 11900, 12000, 14200, 14400, 14600, 13800, 13600, 13500, 14000, 15000.
- R9: Let d be 4 for codes 0, 23 and 24 to 31, and 3 for every other code. Then pciFreq = floor((cpuFreq + floor(d/2)) / d) and agpFreq = floor((2*cpuFreq + floor(d/2)) / d).
- R10: Addresses 3 to 7 are undefined. Writes to them change no register, and reads of them return 8'h00.
- R11: freqReload is 1 for exactly the one cycle in which freqCode first shows a new value. A write that leaves freqCode unchanged gives no pulse.
- R12: rdData returns the addressed register's contents in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; straps are sampled while low |
| fsPins | input | 3 | Frequency-select strap pins |
| spreadPinN | input | 1 | Active-low spread request pin used in pin-source mode |
| wrEn | input | 1 | Write enable |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| freqCode | output | 5 | Effective frequency code |
| freqReload | output | 1 | One-cycle strobe on a change of freqCode |
| spreadOn | output | 1 | Spread-spectrum enable |
| refEn | output | 2 | Reference clock enables |
| clk48En | output | 1 | 48 MHz output enable |
| clk2448En | output | 1 | 24/48 MHz output enable |
| agpEn | output | 2 | AGP clock enables |
| cpuEn | output | 3 | CPU pair enables |
| pciEn | output | 7 | PCI clock enables |
| sdramFbEn | output | 1 | SDRAM feedback output enable |
| cpuFreq | output | 16 | CPU target frequency, 10 kHz units |
| pciFreq | output | 16 | PCI target frequency, 10 kHz units |
| agpFreq | output | 16 | AGP target frequency, 10 kHz units |

## Verification
The strap path is swept through all eight values, each applied under its own reset. That sweep separates the latched straps from their later changes, and it shows that the upper code bits stay zero in pin mode. The register source is then driven through all 32 codes in sequence, with spread alternating against the pin. That sweep shows that both sources switch together, that every decoded frequency matches the arithmetic rule with both divisors, and that each change produces exactly one reload pulse. A same-value rewrite checks that no pulse appears without a change. Walking-one patterns on both enable registers pin down every bit position. Writes to every undefined address are followed by readback of the defined registers, to show those writes are ignored.

// File: rtl/clkgen_cfg_pkg.sv
package clkgen_cfg_pkg;

  localparam int DATA_W = 8;
  localparam int CODE_W = 5;

  typedef struct packed {
    logic wrOut;
    logic wrPci;
    logic wrMode;
  } cfgStrobes_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_OUT  = 2'd1,
    RD_PCI  = 2'd2,
    RD_MODE = 2'd3
  } rdSel_t;

  // CPU target frequency in 10 kHz units for each code
  function automatic logic [15:0] cpuFreqOf(input logic [CODE_W-1:0] code);
    logic [15:0] f;
    case (code)
      5'd0:  f = 16'd13333;  5'd1:  f = 16'd9500;
      5'd2:  f = 16'd10099;  5'd3:  f = 16'd11500;
      5'd4:  f = 16'd10070;  5'd5:  f = 16'd10300;
      5'd6:  f = 16'd10500;  5'd7:  f = 16'd11000;
      5'd8:  f = 16'd10200;  5'd9:  f = 16'd10400;
      5'd10: f = 16'd10600;  5'd11: f = 16'd10700;
      5'd12: f = 16'd10800;  5'd13: f = 16'd10900;
      5'd14: f = 16'd9000;   5'd15: f = 16'd11100;
      5'd16: f = 16'd11200;  5'd17: f = 16'd11300;
      5'd18: f = 16'd11400;  5'd19: f = 16'd11600;
      5'd20: f = 16'd11700;  5'd21: f = 16'd11800;
      5'd22: f = 16'd11900;  5'd23: f = 16'd12000;
      5'd24: f = 16'd14200;  5'd25: f = 16'd14400;
      5'd26: f = 16'd14600;  5'd27: f = 16'd13800;
      5'd28: f = 16'd13600;  5'd29: f = 16'd13500;
      5'd30: f = 16'd14000;  default: f = 16'd15000;
    endcase
    return f;
  endfunction

  // Codes whose bus clocks divide the CPU clock by four instead of three
  function automatic logic useQuarter(input logic [CODE_W-1:0] code);
    return (code == 5'd0) || (code == 5'd23) || (code[4:3] == 2'b11);
  endfunction

endpackage

// File: rtl/clkgen_cfg_ctrl.sv
module clkgen_cfg_ctrl
  import clkgen_cfg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int OUT_ADDR  = 0,
  parameter int PCI_ADDR  = 1,
  parameter int MODE_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output cfgStrobes_t       strobes,
  output rdSel_t            rdSel
);

  logic hitOut, hitPci, hitMode;

  always_comb begin
    hitOut  = (addr == ADDR_W'(OUT_ADDR));
    hitPci  = (addr == ADDR_W'(PCI_ADDR));
    hitMode = (addr == ADDR_W'(MODE_ADDR));

    strobes.wrOut  = wrEn && hitOut;
    strobes.wrPci  = wrEn && hitPci;
    strobes.wrMode = wrEn && hitMode;

    if (hitOut)       rdSel = RD_OUT;
    else if (hitPci)  rdSel = RD_PCI;
    else if (hitMode) rdSel = RD_MODE;
    else              rdSel = RD_NONE;
  end

  // R10: at most one register is written per cycle
  a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R10: no strobe without a write request
  a_r10_idle_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strobes == '0));

endmodule

// File: rtl/clkgen_cfg_dp.sv
module clkgen_cfg_dp
  import clkgen_cfg_pkg::*;
#(
  parameter int FREQ_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         fsPins,
  input  logic               spreadPinN,
  input  cfgStrobes_t        strobes,
  input  rdSel_t             rdSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [CODE_W-1:0]  freqCode,
  output logic               freqReload,
  output logic               spreadOn,
  output logic [1:0]         refEn,
  output logic               clk48En,
  output logic               clk2448En,
  output logic [1:0]         agpEn,
  output logic [2:0]         cpuEn,
  output logic [6:0]         pciEn,
  output logic               sdramFbEn,
  output logic [FREQ_W-1:0]  cpuFreq,
  output logic [FREQ_W-1:0]  pciFreq,
  output logic [FREQ_W-1:0]  agpFreq
);

  localparam int SUM_W = FREQ_W + 2;

  logic [DATA_W-1:0] outReg, pciReg, modeReg;
  logic [2:0]        fsLatch;
  logic [CODE_W-1:0] prevCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg   <= '1;
      pciReg   <= '1;
      modeReg  <= {1'b0, 2'b00, fsPins, 1'b0, 1'b1};
      fsLatch  <= fsPins;
      prevCode <= {2'b00, fsPins};
    end else begin
      if (strobes.wrOut)  outReg  <= wrData;
      if (strobes.wrPci)  pciReg  <= wrData;
      if (strobes.wrMode) modeReg <= wrData;
      prevCode <= freqCode;
    end
  end

  logic regSource;
  assign regSource = modeReg[1];

  always_comb begin
    freqCode   = regSource ? modeReg[6:2] : {2'b00, fsLatch};
    spreadOn   = regSource ? modeReg[7] : !spreadPinN;
    freqReload = (freqCode != prevCode);
  end

  assign refEn     = {pciReg[7], outReg[7]};
  assign clk2448En = outReg[6];
  assign clk48En   = outReg[5];
  assign agpEn     = outReg[4:3];
  assign cpuEn     = outReg[2:0];
  assign pciEn     = pciReg[6:0];
  assign sdramFbEn = modeReg[0];

  always_comb begin
    case (rdSel)
      RD_OUT:  rdData = outReg;
      RD_PCI:  rdData = pciReg;
      RD_MODE: rdData = modeReg;
      default: rdData = '0;
    endcase
  end

  // Frequency decode
  logic              quarter;
  logic [SUM_W-1:0]  cpuWide, rnd, pciSum, agpSum, pciQ, agpQ;

  always_comb begin
    cpuFreq = FREQ_W'(cpuFreqOf(freqCode));
    quarter = useQuarter(freqCode);
    cpuWide = SUM_W'(cpuFreq);
    rnd     = quarter ? SUM_W'(2) : SUM_W'(1);
    pciSum  = cpuWide + rnd;
    agpSum  = (cpuWide << 1) + rnd;
    pciQ    = quarter ? (pciSum >> 2) : (pciSum / SUM_W'(3));
    agpQ    = quarter ? (agpSum >> 2) : (agpSum / SUM_W'(3));
    pciFreq = pciQ[FREQ_W-1:0];
    agpFreq = agpQ[FREQ_W-1:0];
  end

  // R2: straps hold once reset has been released
  a_r2_strap_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(fsLatch));

  // R3: pin source never reaches the upper half of the code space
  a_r3_pin_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    !regSource |-> (freqCode[4:3] == 2'b00));

  // R9: AGP stays within one unit of twice PCI
  a_r9_agp_twice_pci: assert property (@(posedge clk) disable iff (!rstN)
    ((agpFreq + 1'b1) >= (pciFreq << 1)) && (agpFreq <= (pciFreq << 1) + 1'b1));

  // R10: registers hold when nothing is written
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> ($stable(outReg) && $stable(pciReg) && $stable(modeReg)));

  // R11: a register-mode write of a new code is followed by a reload pulse
  a_r11_reload_on_code_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrMode && regSource && wrData[1] && (wrData[6:2] != modeReg[6:2]))
      |=> freqReload);

  // R11: the pulse never lasts two cycles without a second write
  a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    (freqReload && !strobes.wrMode) |=> !freqReload);

endmodule

// File: rtl/clkgen_cfg_bank.sv
module clkgen_cfg_bank
  import clkgen_cfg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int OUT_ADDR  = 0,
  parameter int PCI_ADDR  = 1,
  parameter int MODE_ADDR = 2,
  parameter int FREQ_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        fsPins,
  input  logic              spreadPinN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [4:0]        freqCode,
  output logic              freqReload,
  output logic              spreadOn,
  output logic [1:0]        refEn,
  output logic              clk48En,
  output logic              clk2448En,
  output logic [1:0]        agpEn,
  output logic [2:0]        cpuEn,
  output logic [6:0]        pciEn,
  output logic              sdramFbEn,
  output logic [FREQ_W-1:0] cpuFreq,
  output logic [FREQ_W-1:0] pciFreq,
  output logic [FREQ_W-1:0] agpFreq
);

  cfgStrobes_t strobes;
  rdSel_t      rdSel;

  clkgen_cfg_ctrl #(
    .ADDR_W(ADDR_W), .OUT_ADDR(OUT_ADDR), .PCI_ADDR(PCI_ADDR), .MODE_ADDR(MODE_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .strobes(strobes), .rdSel(rdSel)
  );

  clkgen_cfg_dp #(.FREQ_W(FREQ_W)) dp_i (
    .clk(clk), .rstN(rstN), .fsPins(fsPins), .spreadPinN(spreadPinN),
    .strobes(strobes), .rdSel(rdSel), .wrData(wrData), .rdData(rdData),
    .freqCode(freqCode), .freqReload(freqReload), .spreadOn(spreadOn),
    .refEn(refEn), .clk48En(clk48En), .clk2448En(clk2448En), .agpEn(agpEn),
    .cpuEn(cpuEn), .pciEn(pciEn), .sdramFbEn(sdramFbEn),
    .cpuFreq(cpuFreq), .pciFreq(pciFreq), .agpFreq(agpFreq)
  );

endmodule

// File: tb/clkgen_cfg_bank_tb_top.sv
`timescale 1ns/1ps
module clkgen_cfg_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  fsPins = 3'd0;
  logic        spreadPinN = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  wrData = 8'd0;
  logic [7:0]  rdData;
  logic [4:0]  freqCode;
  logic        freqReload, spreadOn, clk48En, clk2448En, sdramFbEn;
  logic [1:0]  refEn, agpEn;
  logic [2:0]  cpuEn;
  logic [6:0]  pciEn;
  logic [15:0] cpuFreq, pciFreq, agpFreq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  clkgen_cfg_bank dut_i (
    .clk(clk), .rstN(rstN), .fsPins(fsPins), .spreadPinN(spreadPinN),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .freqCode(freqCode), .freqReload(freqReload), .spreadOn(spreadOn),
    .refEn(refEn), .clk48En(clk48En), .clk2448En(clk2448En), .agpEn(agpEn),
    .cpuEn(cpuEn), .pciEn(pciEn), .sdramFbEn(sdramFbEn),
    .cpuFreq(cpuFreq), .pciFreq(pciFreq), .agpFreq(agpFreq)
  );

  function automatic int expCpu(input int c);
    int t[32] = '{13333, 9500, 10099, 11500, 10070, 10300, 10500, 11000,
                  10200, 10400, 10600, 10700, 10800, 10900, 9000, 11100,
                  11200, 11300, 11400, 11600, 11700, 11800, 11900, 12000,
                  14200, 14400, 14600, 13800, 13600, 13500, 14000, 15000};
    return t[c];
  endfunction

  function automatic int expDiv(input int c);
    return (c == 0 || c == 23 || c >= 24) ? 4 : 3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] fs);
    rstN = 1'b0;
    fsPins = fs;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic checkFreqs(input string tag, input int c);
    int d;
    d = expDiv(c);
    check({tag, " R8 cpuFreq"}, int'(cpuFreq), expCpu(c));
    check({tag, " R9 pciFreq"}, int'(pciFreq), (expCpu(c) + d / 2) / d);
    check({tag, " R9 agpFreq"}, int'(agpFreq), (2 * expCpu(c) + d / 2) / d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    // R1 reset state
    doReset(3'b101);
    check("R1 refEn", int'(refEn), 3);
    check("R1 cpuEn", int'(cpuEn), 7);
    check("R1 pciEn", int'(pciEn), 127);
    check("R1 agp/48/2448", int'({agpEn, clk48En, clk2448En}), 15);
    check("R1 sdramFbEn", int'(sdramFbEn), 1);
    check("R1 freqReload", int'(freqReload), 0);
    check("R1 spreadOn", int'(spreadOn), 0);
    readReg(3'd0, rd); check("R1 R12 out readback", int'(rd), 8'hFF);
    readReg(3'd1, rd); check("R1 R12 pci readback", int'(rd), 8'hFF);
    readReg(3'd2, rd); check("R1 R12 mode readback", int'(rd), 8'h15);

    // R2 strap change after reset is ignored
    fsPins = 3'b010;
    repeat (3) @(negedge clk);
    check("R2 freqCode after strap change", int'(freqCode), 5);
    readReg(3'd2, rd); check("R2 mode readback", int'(rd), 8'h15);

    // R3 pin-source sweep over all straps
    for (int fs = 0; fs < 8; fs++) begin
      doReset(3'(fs));
      check("R3 freqCode", int'(freqCode), fs);
      checkFreqs("R3", fs);
      spreadPinN = 1'b0; #1;
      check("R3 spread pin low", int'(spreadOn), 1);
      spreadPinN = 1'b1; #1;
      check("R3 spread pin high", int'(spreadOn), 0);
    end

    // R4 register-source sweep, R11 reload per change
    for (int c = 0; c < 32; c++) begin
      spreadPinN = (c % 2 == 1) ? 1'b1 : 1'b0;
      writeReg(3'd2, {1'(c % 2), 5'(c), 1'b1, 1'b1});
      check("R11 reload after change", int'(freqReload), 1);
      check("R4 freqCode", int'(freqCode), c);
      check("R4 spreadOn from bit 7", int'(spreadOn), c % 2);
      checkFreqs("R4", c);
      @(negedge clk);
      check("R11 reload single cycle", int'(freqReload), 0);
    end
    // R11 same-value rewrite gives no pulse
    writeReg(3'd2, {1'b1, 5'd31, 1'b1, 1'b1});
    check("R11 no reload on same code", int'(freqReload), 0);
    // back to pin source: straps were 7 at last reset
    writeReg(3'd2, {1'b1, 5'd20, 1'b0, 1'b1});
    check("R3 back to pin freqCode", int'(freqCode), 7);
    check("R11 reload on source switch", int'(freqReload), 1);
    spreadPinN = 1'b1; #1;
    check("R3 pin spread ignores bit 7", int'(spreadOn), 0);

    // R7 sdram feedback enable
    writeReg(3'd2, 8'h00);
    check("R7 sdramFbEn off", int'(sdramFbEn), 0);
    writeReg(3'd2, 8'h01);
    check("R7 sdramFbEn on", int'(sdramFbEn), 1);

    // R5 and R6 walking ones
    for (int i = 0; i < 8; i++) begin
      writeReg(3'd0, 8'(1 << i));
      check("R5 out map", int'({refEn[0], clk2448En, clk48En, agpEn, cpuEn}), 1 << i);
      writeReg(3'd1, 8'(1 << i));
      check("R6 pci map", int'({refEn[1], pciEn}), 1 << i);
      readReg(3'd1, rd); check("R12 pci readback", int'(rd), 1 << i);
    end

    // R10 undefined addresses
    writeReg(3'd0, 8'h5A);
    writeReg(3'd1, 8'hC3);
    writeReg(3'd2, 8'h81);
    for (int a = 3; a < 8; a++) begin
      writeReg(3'(a), 8'hFF);
      writeReg(3'(a), 8'h26);
      readReg(3'(a), rd); check("R10 undefined read", int'(rd), 0);
    end
    readReg(3'd0, rd); check("R10 out unchanged", int'(rd), 8'h5A);
    readReg(3'd1, rd); check("R10 pci unchanged", int'(rd), 8'hC3);
    readReg(3'd2, rd); check("R10 mode unchanged", int'(rd), 8'h81);
    check("R10 freqCode unchanged", int'(freqCode), 7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule